// File: doc/BRIEF.md
# Floating-point to logarithm converter

This block takes a 32-bit single-precision floating-point word and returns its base-2 logarithm in fixed point. The unbiased exponent becomes the signed integer part. The fractional part, log2(1+m) for the mantissa fraction m, is approximated by a straight line a·m + b. The slope and offset of that line are chosen per mantissa region. There are fifteen regions, and they are narrower near m = 0, where the curve bends most.

The slope is never multiplied. It is the sum of three right-shifted copies of the mantissa. These copies and the offset go through a two-level carry-save tree and a single carry-propagate adder. The slope shifts and offsets are computed while the design elaborates, from the region boundaries. The outputs are registered, so results appear one clock after the input. A zero exponent field, which covers zero and denormals, raises a zero flag and clears the magnitude fields. The sign bit passes straight through. Infinities and NaNs are outside the intended input range.

Top module: `fplog_conv`

## Requirements
- R1: Every output reflects the input word sampled at the previous rising clock edge: exactly one cycle of latency.
- R2: While rst_ni is low, int_o, frac_o, sign_o and zero_o are all 0.
- R3: For an exponent field E in 1..254 (bits 30:23), int_o equals E-127 as 8-bit two's complement.
- R4: When the exponent field is 0, zero_o is 1 and int_o and frac_o are 0, whatever the mantissa. When the exponent field is nonzero, zero_o is 0.
- R5: sign_o equals input bit 31 for every input, including zero.
- R6: For a nonzero exponent field, frac_o/2^24 is within 0.0041 (68786 LSB) of log2(1+m), where m is bits 22:0 divided by 2^23.
- R7: The mantissa splits into 15 regions, with boundaries at m·64 = 0,1,2,4,6,8,12,16,20,24,28,32,40,48,56,64. Within one region, frac_o never decreases as the mantissa grows.
- R8: frac_o saturates instead of wrapping. The largest mantissa (all ones) gives frac_o ≥ 24'hFF0000.
- R9: frac_o depends only on the mantissa. The same mantissa with different nonzero exponents gives identical frac_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fp_i | input | 32 | Floating-point operand: sign bit 31, biased exponent 30:23, mantissa 22:0 |
| int_o | output | 8 | Integer part of the logarithm, two's complement |
| frac_o | output | 24 | Fractional part of the logarithm, unsigned, weight 2^-24 per LSB |
| sign_o | output | 1 | Sign of the operand |
| zero_o | output | 1 | Operand has a zero exponent field |

## Verification
A wrong region index or a corrupted coefficient has a distinctive symptom. Within one cycle, frac_o falls outside the error bound for mantissas in a single region, or it steps down inside a region. Sweeping the mantissa densely across all fifteen regions, and probing just either side of each boundary, brings such faults to the port on the next clock. A carry lost in the compressor tree or a dropped saturation shows up the same cycle as a large error or a wrap near the top of the mantissa range. Exponent and zero-path faults show at int_o and zero_o one cycle after the offending input.

// File: rtl/fplog_pkg.sv
package fplog_pkg;
  localparam int EXP_W     = 8;
  localparam int MANT_W    = 23;
  localparam int FP_W      = 1 + EXP_W + MANT_W;
  localparam int FRAC_W    = 24;
  localparam int EXP_BIAS  = 127;
  localparam int N_REG     = 15;
  localparam int IDX_W     = $clog2(N_REG);
  localparam int DEC_W     = 6;        // mantissa bits seen by the region decoder
  localparam int SUM_W     = FRAC_W + 2;
  localparam int SH_W      = 5;
  localparam int SH_MAX    = 12;       // largest real shift tried for a slope term
  localparam logic [SH_W-1:0] SH_NONE = '1;
  localparam longint ONE_Q = 64'sd1 <<< 30;

  typedef struct packed {
    logic [FRAC_W-1:0] ofs;
    logic [SH_W-1:0]   sh0;
    logic [SH_W-1:0]   sh1;
    logic [SH_W-1:0]   sh2;
  } coef_t;

  // region start in units of 1/64 of the mantissa range
  function automatic int region_lo(input int k);
    case (k)
      0: return 0;   1: return 1;   2: return 2;   3: return 4;
      4: return 6;   5: return 8;   6: return 12;  7: return 16;
      8: return 20;  9: return 24;  10: return 28; 11: return 32;
      12: return 40; 13: return 48; 14: return 56; default: return 64;
    endcase
  endfunction

  // log2 of x in [1,2], both Q30, by repeated squaring
  function automatic longint log2_q30(input longint x);
    longint v;
    longint r;
    v = x;
    r = 0;
    for (int i = 0; i < 30; i++) begin
      v = (v * v) >>> 30;
      if (v >= (ONE_Q <<< 1)) begin
        v = v >>> 1;
        r = r | (ONE_Q >>> (i + 1));
      end
    end
    return r;
  endfunction

  function automatic longint term_q30(input int i);
    return (i > SH_MAX) ? 64'sd0 : (ONE_Q >>> i);
  endfunction

  function automatic logic [SH_W-1:0] sh_code(input int i);
    return (i > SH_MAX) ? SH_NONE : SH_W'(i);
  endfunction

  // slope = nearest sum of three powers of two to the chord; offset = minimax
  function automatic coef_t region_coef(input int k);
    coef_t  c;
    longint ml, mh, fl, fh, chord, best, err, aq, g, gmin, gmax, m, b;
    int     bi, bj, bl;
    ml    = longint'(region_lo(k)) <<< 24;
    mh    = longint'(region_lo(k + 1)) <<< 24;
    fl    = log2_q30(ONE_Q + ml);
    fh    = log2_q30(ONE_Q + mh);
    chord = ((fh - fl) <<< 30) / (mh - ml);
    best  = ONE_Q <<< 3;
    bi = 0; bj = 0; bl = 0;
    for (int i = 0; i <= SH_MAX + 1; i++) begin
      for (int j = i; j <= SH_MAX + 1; j++) begin
        for (int l = j; l <= SH_MAX + 1; l++) begin
          err = chord - (term_q30(i) + term_q30(j) + term_q30(l));
          if (err < 0) err = -err;
          if (err < best) begin
            best = err; bi = i; bj = j; bl = l;
          end
        end
      end
    end
    aq   = term_q30(bi) + term_q30(bj) + term_q30(bl);
    gmin = ONE_Q <<< 2;
    gmax = -(ONE_Q <<< 2);
    for (int s = 0; s <= 16; s++) begin
      m = ml + ((mh - ml) * s) / 16;
      g = log2_q30(ONE_Q + m) - ((aq * m) >>> 30);
      if (g < gmin) gmin = g;
      if (g > gmax) gmax = g;
    end
    b = (((gmin + gmax) >>> 1) + 32) >>> 6;
    if (b < 0) b = 0;
    if (b > (64'sd1 <<< FRAC_W) - 1) b = (64'sd1 <<< FRAC_W) - 1;
    c.ofs = FRAC_W'(b);
    c.sh0 = sh_code(bi);
    c.sh1 = sh_code(bj);
    c.sh2 = sh_code(bl);
    return c;
  endfunction
endpackage

// File: rtl/fplog_region_dec.sv
module fplog_region_dec
  import fplog_pkg::*;
(
  input  logic [DEC_W-1:0] top_i,
  output logic [IDX_W-1:0] idx_o
);
  // leading-one priority: narrower regions get more decode bits
  always_comb begin
    if (top_i[5])      idx_o = IDX_W'(11) + IDX_W'(top_i[4:3]);
    else if (top_i[4]) idx_o = IDX_W'(7)  + IDX_W'(top_i[3:2]);
    else if (top_i[3]) idx_o = IDX_W'(5)  + IDX_W'(top_i[2]);
    else if (top_i[2]) idx_o = IDX_W'(3)  + IDX_W'(top_i[1]);
    else if (top_i[1]) idx_o = IDX_W'(2);
    else if (top_i[0]) idx_o = IDX_W'(1);
    else               idx_o = '0;
  end
endmodule

// File: rtl/fplog_csa.sv
module fplog_csa #(
  parameter int W = 26
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cry_o
);
  assign sum_o = a_i ^ b_i ^ c_i;
  assign cry_o = ((a_i & b_i) | (a_i & c_i) | (b_i & c_i)) << 1;
endmodule

// File: rtl/fplog_frac.sv
module fplog_frac
  import fplog_pkg::*;
(
  input  logic [MANT_W-1:0] mant_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [FRAC_W-1:0] frac_o
);
  coef_t coef_tab [N_REG];
  for (genvar k = 0; k < N_REG; k++) begin : g_coef
    localparam coef_t RC = region_coef(k);
    assign coef_tab[k] = RC;
  end

  coef_t             sel;
  logic [FRAC_W-1:0] m_q;
  logic [SUM_W-1:0]  t0, t1, t2, ofs_x;
  logic [SUM_W-1:0]  s_a, c_a, s_b, c_b, total;

  assign sel   = (idx_i < IDX_W'(N_REG)) ? coef_tab[idx_i] : '0;
  assign m_q   = {mant_i, 1'b0};
  assign t0    = {2'b00, m_q >> sel.sh0};
  assign t1    = {2'b00, m_q >> sel.sh1};
  assign t2    = {2'b00, m_q >> sel.sh2};
  assign ofs_x = {2'b00, sel.ofs};

  fplog_csa #(.W(SUM_W)) u_csa_a (.a_i(t0),  .b_i(t1),  .c_i(t2),    .sum_o(s_a), .cry_o(c_a));
  fplog_csa #(.W(SUM_W)) u_csa_b (.a_i(s_a), .b_i(c_a), .c_i(ofs_x), .sum_o(s_b), .cry_o(c_b));

  assign total  = s_b + c_b;
  assign frac_o = (|total[SUM_W-1:FRAC_W]) ? '1 : total[FRAC_W-1:0];

  always_comb begin
    AST_CSA_KEEPS_SUM: assert (s_b + c_b == t0 + t1 + t2 + ofs_x); // R6
  end
endmodule

// File: rtl/fplog_conv.sv
module fplog_conv
  import fplog_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] fp_i,
  output logic [7:0]  int_o,
  output logic [23:0] frac_o,
  output logic        sign_o,
  output logic        zero_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [MANT_W-1:0] mant_f;
  logic              is_zero;
  logic [IDX_W-1:0]  reg_idx;
  logic [FRAC_W-1:0] frac_c;
  logic [EXP_W-1:0]  int_c;

  assign exp_f   = fp_i[FP_W-2 -: EXP_W];
  assign mant_f  = fp_i[MANT_W-1:0];
  assign is_zero = (exp_f == '0);
  assign int_c   = exp_f - EXP_W'(EXP_BIAS);

  fplog_region_dec u_dec (
    .top_i (mant_f[MANT_W-1 -: DEC_W]),
    .idx_o (reg_idx)
  );

  fplog_frac u_frac (
    .mant_i (mant_f),
    .idx_i  (reg_idx),
    .frac_o (frac_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_o  <= '0;
      frac_o <= '0;
      sign_o <= 1'b0;
      zero_o <= 1'b0;
    end else begin
      int_o  <= is_zero ? '0 : int_c;
      frac_o <= is_zero ? '0 : frac_c;
      sign_o <= fp_i[FP_W-1];
      zero_o <= is_zero;
    end
  end

  AST_INT_UNBIASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fp_i[30:23] != 8'd0) |=> (int_o == 8'($past(fp_i[30:23]) - 8'd127))); // R3
  AST_ZERO_RAISED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fp_i[30:23] == 8'd0) |=> zero_o); // R4
  AST_ZERO_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |-> (int_o == 8'd0 && frac_o == 24'd0)); // R4
  AST_SIGN_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (sign_o == $past(fp_i[31]))); // R5
endmodule

// File: tb/fplog_conv_bench.sv
`timescale 1ns/1ps
module fplog_conv_bench;
  localparam time CLK_PER = 20ns;
  localparam int  WD_CYC  = 150000;
  localparam int  TOL     = 68786;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fp = '0;
  logic [7:0]  int_w;
  logic [23:0] frac_w;
  logic        sign_w, zero_w;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  fplog_conv u_fplog_conv (
    .clk_i (clk), .rst_ni (rst_n), .fp_i (fp),
    .int_o (int_w), .frac_o (frac_w), .sign_o (sign_w), .zero_o (zero_w)
  );

  int bnd [16] = '{0, 1, 2, 4, 6, 8, 12, 16, 20, 24, 28, 32, 40, 48, 56, 64};

  function automatic logic [31:0] mk(input bit s, input int e, input int m);
    return {s, 8'(e), 23'(m)};
  endfunction

  function automatic real ref_frac(input int m);
    return $ln(1.0 + real'(m) / 8388608.0) / $ln(2.0) * 16777216.0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic apply(input logic [31:0] x);
    @(negedge clk);
    fp = x;
    @(negedge clk);
  endtask

  task automatic t_reset;
    fp = mk(1'b1, 200, 12345);
    repeat (3) @(negedge clk);
    chk(int_w == 0 && frac_w == 0 && sign_w == 0 && zero_w == 0, "R2", "outputs in reset",
        {int_w, frac_w, sign_w, zero_w}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_latency;
    apply(mk(1'b0, 130, 0));
    chk(int_w == 8'd3, "R1", "first result one cycle later", int_w, 3);
    fp = mk(1'b1, 120, 0);
    #1;
    chk(int_w == 8'd3 && sign_w == 1'b0, "R1", "output held before edge", int_w, 3);
    @(negedge clk);
    chk(int_w == 8'(-7) && sign_w == 1'b1, "R1", "second result next cycle", int_w, 8'(-7));
  endtask

  task automatic t_exponent;
    int es [6] = '{1, 100, 126, 127, 128, 254};
    foreach (es[i]) begin
      apply(mk(1'b0, es[i], 4242));
      chk(int_w == 8'(es[i] - 127), "R3", "integer part", int_w, 8'(es[i] - 127));
      chk(zero_w == 1'b0, "R4", "zero flag low for nonzero exponent", zero_w, 0);
    end
  endtask

  task automatic t_zero;
    int ms [3] = '{0, 1, 8388607};
    foreach (ms[i]) begin
      apply(mk(1'b0, 0, ms[i]));
      chk(zero_w == 1'b1, "R4", "zero flag", zero_w, 1);
      chk(int_w == 0 && frac_w == 0, "R4", "flushed magnitude", {int_w, frac_w}, 0);
    end
  endtask

  task automatic t_sign;
    apply(mk(1'b1, 0, 0));
    chk(sign_w == 1'b1, "R5", "negative zero sign", sign_w, 1);
    apply(mk(1'b1, 140, 777));
    chk(sign_w == 1'b1, "R5", "negative sign", sign_w, 1);
    apply(mk(1'b0, 140, 777));
    chk(sign_w == 1'b0, "R5", "positive sign", sign_w, 0);
  endtask

  task automatic acc_one(input int m);
    real d;
    apply(mk(1'b0, 127, m));
    d = real'(frac_w) - ref_frac(m);
    if (d < 0.0) d = -d;
    chk(d <= real'(TOL), "R6", $sformatf("accuracy m=%0d", m), frac_w, longint'(ref_frac(m)));
  endtask

  task automatic t_accuracy;
    for (int i = 0; i < 4096; i++) acc_one((i << 11) | ((i * 37) & 11'h7ff));
    for (int k = 1; k < 15; k++) begin
      acc_one((bnd[k] << 17) - 1);
      acc_one(bnd[k] << 17);
    end
    acc_one(1);
    acc_one(8388607);
  endtask

  task automatic t_monotonic;
    for (int k = 0; k < 15; k++) begin
      int lo = bnd[k] << 17;
      int hi = (bnd[k + 1] << 17) - 1;
      logic [23:0] prev = '0;
      for (int s = 0; s <= 4; s++) begin
        apply(mk(1'b0, 127, lo + ((hi - lo) / 4) * s));
        if (s > 0)
          chk(frac_w >= prev, "R7", $sformatf("nondecreasing in region %0d", k), frac_w, prev);
        prev = frac_w;
      end
    end
  endtask

  task automatic t_saturate;
    apply(mk(1'b0, 127, 8388607));
    chk(frac_w >= 24'hFF0000, "R8", "top mantissa no wrap", frac_w, 24'hFF0000);
    apply(mk(1'b0, 127, 8388607 - 4096));
    chk(frac_w >= 24'hFF0000, "R8", "near-top mantissa no wrap", frac_w, 24'hFF0000);
  endtask

  task automatic t_exp_indep;
    int ms [4] = '{5, 300000, 4194304, 8000000};
    int es [3] = '{1, 90, 254};
    foreach (ms[i]) begin
      logic [23:0] base;
      apply(mk(1'b0, 127, ms[i]));
      base = frac_w;
      foreach (es[j]) begin
        apply(mk(1'b0, es[j], ms[i]));
        chk(frac_w == base, "R9", "fraction independent of exponent", frac_w, base);
      end
    end
  endtask

  initial begin
    t_reset();
    t_latency();
    t_exponent();
    t_zero();
    t_sign();
    t_accuracy();
    t_monotonic();
    t_saturate();
    t_exp_indep();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule